// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block is the digital model of a serial non-volatile memory of 16-bit words that answers a host on a Microwire bus. The host raises the select line and shifts in a frame on the serial clock: any number of leading zeros, a start bit, a two-bit opcode, an address field and, for writes, one data word. The block decodes reads, word writes, word erases, whole-array writes and erases, and the set and clear commands for its write-enable latch. A read returns words MSB first. If the host keeps clocking, the read continues through the following addresses and wraps from the last word back to word 0. A write-class frame programs the array only when the select line falls and only while the latch is set. A cycle counter then stands in for the programming time. While that counter runs, the data output tells the host whether the array is busy or ready.

All three serial inputs are sampled by the system clock. A serial clock edge is therefore an event that spans several system cycles. Two inputs come from outside the block: a cancel pulse from a separate clock-count guard, and a low-supply or power-up flag. Either one discards a pending write. The low-supply flag also clears the latch.

The parser has seven states. IDLE waits for a start bit. OPC takes the two opcode bits. ADDR takes the address field. RDATA shifts read data out. WDATA takes the 16 data bits. ARMED waits for the select line to fall. BUSY lasts while programming runs. The transitions are as follows:
- start-bit (IDLE to OPC)
- opcode-done (OPC to ADDR)
- addr-read (ADDR to RDATA)
- addr-data (ADDR to WDATA)
- addr-nodata (ADDR to ARMED)
- data-done (WDATA to ARMED)
- commit (ARMED to BUSY)
- latch-or-refuse (ARMED to IDLE)
- abort (OPC, ADDR, RDATA or WDATA to IDLE when the select line drops; WDATA or ARMED to IDLE on cancel or low supply)
- prog-done (BUSY to IDLE, which sets the verify flag)

Top module: `mw_eeprom`

## Requirements
- R1: After reset every word reads FFFFh, the data output is not enabled and the write-enable latch is clear.
- R2: With the select line high, zeros sampled on serial clock rises before the first one are ignored; that first one is the start bit.
- R3: The opcode bits that follow the start bit mean: 10 read, 01 write, 11 erase. For opcode 00, the top two address bits select the command: 01 write-all, 10 erase-all, 11 latch set, 00 latch clear. With 64 words the address field is 6 bits. After the last address bit of a read, the output is enabled and shows 0. The 16 data bits then follow MSB first, one per serial clock rise.
- R4: If the serial clock keeps running after a word has been read, the next address follows with no gap, and the last address wraps to 0.
- R5: A write programs the addressed word with the 16 shifted data bits when the select line falls, but only if the latch is set. The latch-set and latch-clear commands take effect on the fall of the select line.
- R6: Erase sets only the addressed word to FFFFh.
- R7: Write-all puts the shifted word into every address. Erase-all puts FFFFh into every address.
- R8: While programming runs, serial clock and data are ignored. With the select line high the output shows 0 while busy and 1 once ready. With the select line low the output is disabled.
- R9: A one sampled at a serial clock rise while ready is shown is taken as a start bit, and the output is disabled at once.
- R10: A select line fall before a frame is complete discards that frame.
- R11: A cancel pulse before the select line falls discards a pending write.
- R12: The low-supply flag clears the latch and discards a pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| guard_cancel | input | 1 | Cancel pulse from the clock-count guard |
| supply_low | input | 1 | Low-supply or power-up indication |
| do_data | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for do_data (low means high impedance) |

## Verification
The bench builds the block with 64 words and a programming time of 200 cycles. The small array lets the bench write every address with a computed pattern. It then reads all 64 words plus one more in a single sequential read, which covers every address-increment step and the wrap. The short programming time makes it possible to check the busy level, the ready level and the disabled output within one verify period, and to test a start bit sent while the output shows ready.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_ARMED,
        ST_BUSY
    } mw_state_e;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_WRALL,
        CMD_ERALL,
        CMD_WEN,
        CMD_WDIS
    } mw_cmd_e;

    // The opcode picks the command; opcode 00 borrows the top two address bits.
    function automatic mw_cmd_e mw_decode(input logic [1:0] op, input logic [1:0] sub);
        mw_cmd_e c;
        case (op)
            2'b10:   c = CMD_READ;
            2'b01:   c = CMD_WRITE;
            2'b11:   c = CMD_ERASE;
            default: begin
                case (sub)
                    2'b01:   c = CMD_WRALL;
                    2'b10:   c = CMD_ERALL;
                    2'b11:   c = CMD_WEN;
                    default: c = CMD_WDIS;
                endcase
            end
        endcase
        return c;
    endfunction

    function automatic logic mw_is_prog(input mw_cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_WRALL) || (c == CMD_ERALL);
    endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_lvl,
    output logic di_lvl,
    output logic sk_rise
);
    logic sk_q;
    logic sk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_lvl  <= 1'b0;
            di_lvl  <= 1'b0;
            sk_q    <= 1'b0;
            sk_prev <= 1'b0;
        end else begin
            cs_lvl  <= cs;
            di_lvl  <= di;
            sk_q    <= sk;
            sk_prev <= sk_q;
        end
    end

    assign sk_rise = sk_q & ~sk_prev;

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start)         cnt_q <= TW'(CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == TW'(1));

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R8

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_one,
    input  logic              we_all,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[g] <= '1;
            else if (we_all || (we_one && (waddr == IDX_W'(g))))
                mem_q[g] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    AST_ONE_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_one && we_all)); // R7

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int WORDS       = 64,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic guard_cancel,
    input  logic supply_low,
    output logic do_data,
    output logic do_oe
);
    localparam int SLOTS = (WORDS > 64) ? 8 : 6;
    localparam int IDX_W = $clog2(WORDS);
    localparam int CNT_W = $clog2((DATA_W > SLOTS) ? DATA_W : SLOTS);

    logic cs_lvl, di_lvl, sk_rise;

    mw_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .di      (di),
        .cs_lvl  (cs_lvl),
        .di_lvl  (di_lvl),
        .sk_rise (sk_rise)
    );

    mw_state_e         state, state_n;
    mw_cmd_e           cmd_q, cmd_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [1:0]        op_q, op_n;
    logic [SLOTS-1:0]  addr_q, addr_n, addr_full;
    logic [DATA_W-1:0] sh_q, sh_n;
    logic [IDX_W-1:0]  idx_q, idx_n, rd_idx;
    logic              dout_q, dout_n;
    logic              wel_q, wel_n;
    logic              ver_q, ver_n;
    logic              t_start, t_busy, t_done;
    logic              we_one, we_all;
    logic [DATA_W-1:0] wdata, rd_data;

    assign addr_full = {addr_q[SLOTS-2:0], di_lvl};
    assign rd_idx    = (state == ST_ADDR) ? addr_full[IDX_W-1:0] : idx_q + 1'b1;

    mw_word_array #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_one (we_one),
        .we_all (we_all),
        .waddr  (idx_q),
        .wdata  (wdata),
        .raddr  (rd_idx),
        .rdata  (rd_data)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .busy  (t_busy),
        .done  (t_done)
    );

    assign we_one = t_start && ((cmd_q == CMD_WRITE) || (cmd_q == CMD_ERASE));
    assign we_all = t_start && ((cmd_q == CMD_WRALL) || (cmd_q == CMD_ERALL));
    assign wdata  = ((cmd_q == CMD_WRITE) || (cmd_q == CMD_WRALL)) ? sh_q : '1;

    // Next-state and datapath
    always_comb begin
        state_n = state;
        cmd_n   = cmd_q;
        cnt_n   = cnt_q;
        op_n    = op_q;
        addr_n  = addr_q;
        sh_n    = sh_q;
        idx_n   = idx_q;
        dout_n  = dout_q;
        wel_n   = wel_q;
        ver_n   = ver_q;
        t_start = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cs_lvl && sk_rise && di_lvl) begin
                    state_n = ST_OPC;
                    cnt_n   = '0;
                    ver_n   = 1'b0;
                end
            end
            ST_OPC: begin
                if (!cs_lvl) state_n = ST_IDLE;
                else if (sk_rise) begin
                    op_n  = {op_q[0], di_lvl};
                    cnt_n = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        state_n = ST_ADDR;
                        cnt_n   = '0;
                    end
                end
            end
            ST_ADDR: begin
                if (!cs_lvl) state_n = ST_IDLE;
                else if (sk_rise) begin
                    addr_n = addr_full;
                    cnt_n  = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(SLOTS - 1)) begin
                        cmd_n = mw_decode(op_q, addr_full[SLOTS-1:SLOTS-2]);
                        idx_n = addr_full[IDX_W-1:0];
                        cnt_n = '0;
                        case (mw_decode(op_q, addr_full[SLOTS-1:SLOTS-2]))
                            CMD_READ: begin
                                state_n = ST_RDATA;
                                sh_n    = rd_data;
                                dout_n  = 1'b0;
                            end
                            CMD_WRITE, CMD_WRALL: state_n = ST_WDATA;
                            default:              state_n = ST_ARMED;
                        endcase
                    end
                end
            end
            ST_RDATA: begin
                if (!cs_lvl) state_n = ST_IDLE;
                else if (sk_rise) begin
                    dout_n = sh_q[DATA_W-1];
                    if (cnt_q == CNT_W'(DATA_W - 1)) begin
                        sh_n  = rd_data;
                        idx_n = rd_idx;
                        cnt_n = '0;
                    end else begin
                        sh_n  = {sh_q[DATA_W-2:0], 1'b0};
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            ST_WDATA: begin
                if (!cs_lvl || guard_cancel || supply_low) state_n = ST_IDLE;
                else if (sk_rise) begin
                    sh_n  = {sh_q[DATA_W-2:0], di_lvl};
                    cnt_n = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(DATA_W - 1)) state_n = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (guard_cancel || supply_low) state_n = ST_IDLE;
                else if (!cs_lvl) begin
                    state_n = ST_IDLE;
                    if (mw_is_prog(cmd_q)) begin
                        if (wel_q) begin
                            state_n = ST_BUSY;
                            t_start = 1'b1;
                        end
                    end else begin
                        wel_n = (cmd_q == CMD_WEN);
                    end
                end
            end
            ST_BUSY: begin
                if (t_done) begin
                    state_n = ST_IDLE;
                    ver_n   = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (supply_low) wel_n = 1'b0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cmd_q  <= CMD_WDIS;
            cnt_q  <= '0;
            op_q   <= '0;
            addr_q <= '0;
            sh_q   <= '0;
            idx_q  <= '0;
            dout_q <= 1'b0;
            wel_q  <= 1'b0;
            ver_q  <= 1'b0;
        end else begin
            state  <= state_n;
            cmd_q  <= cmd_n;
            cnt_q  <= cnt_n;
            op_q   <= op_n;
            addr_q <= addr_n;
            sh_q   <= sh_n;
            idx_q  <= idx_n;
            dout_q <= dout_n;
            wel_q  <= wel_n;
            ver_q  <= ver_n;
        end
    end

    // Outputs
    always_comb begin
        do_oe   = 1'b0;
        do_data = 1'b0;
        unique case (state)
            ST_RDATA: begin
                do_oe   = cs_lvl;
                do_data = dout_q;
            end
            ST_BUSY: begin
                do_oe   = cs_lvl;
                do_data = 1'b0;
            end
            ST_IDLE: begin
                do_oe   = cs_lvl && ver_q;
                do_data = 1'b1;
            end
            default: begin
                do_oe   = 1'b0;
                do_data = 1'b0;
            end
        endcase
    end

    AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && $past(state) == ST_ADDR) |-> !dout_q); // R3

    AST_TIMER_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        t_busy |-> (state == ST_BUSY)); // R8

    AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |=> (state == ST_BUSY || state == ST_IDLE)); // R8

    AST_LOW_SUPPLY_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> !wel_q); // R12

    AST_CS_DROP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_lvl && (state == ST_OPC || state == ST_ADDR || state == ST_WDATA))
        |=> (state == ST_IDLE)); // R10

    AST_PROG_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_busy) |-> $past(wel_q)); // R5

endmodule

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;
    localparam int WORDS = 64;
    localparam int PROG  = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic guard_cancel = 1'b0, supply_low = 1'b0;
    logic do_data, do_oe;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [WORDS];
    logic s_oe, s_do;

    always #10 clk = ~clk;

    mw_eeprom #(.WORDS(WORDS), .DATA_W(16), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .guard_cancel(guard_cancel), .supply_low(supply_low),
        .do_data(do_data), .do_oe(do_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b);
        di = b;
        wait_clk(3);
        sk = 1'b1;
        wait_clk(4);
        s_oe = do_oe;
        s_do = do_data;
        sk = 1'b0;
        wait_clk(3);
    endtask

    task automatic cs_up();
        cs = 1'b1;
        wait_clk(3);
    endtask

    task automatic cs_dn();
        cs = 1'b0;
        di = 1'b0;
        wait_clk(4);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [5:0] a);
        bit_io(1'b1);
        bit_io(op[1]);
        bit_io(op[0]);
        for (int i = 5; i >= 0; i--) bit_io(a[i]);
    endtask

    task automatic send_word(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) bit_io(d[i]);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [15:0] d);
        cs_up();
        send_hdr(2'b01, a);
        send_word(d);
        cs_dn();
        wait_clk(PROG + 10);
    endtask

    task automatic do_short(input logic [1:0] op, input logic [5:0] a);
        cs_up();
        send_hdr(op, a);
        cs_dn();
        wait_clk(PROG + 10);
    endtask

    task automatic do_read(input string tag, input int dummies, input logic [5:0] a, input int n);
        logic [15:0] got;
        cs_up();
        for (int k = 0; k < dummies; k++) bit_io(1'b0);
        send_hdr(2'b10, a);
        chk("R3 lead oe", int'(s_oe), 1);
        chk("R3 lead zero", int'(s_do), 0);
        for (int w = 0; w < n; w++) begin
            got = '0;
            for (int i = 15; i >= 0; i--) begin
                bit_io(1'b0);
                got[i] = s_do;
            end
            chk(tag, int'(got), int'(model[(int'(a) + w) % WORDS]));
        end
        cs_dn();
        chk("R8 oe off after cs low", int'(do_oe), 0);
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h0405) ^ 16'hC3A0 ^ (a << 11));
    endfunction

    initial begin
        wait_clk(200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        chk("R1 oe after reset", int'(do_oe), 0);

        // R1 / R2: erased contents, with dummy zeros before the start bit
        do_read("R1 R2 reset word", 3, 6'd5, 1);

        // R5: write without latch set has no effect
        do_write(6'd3, 16'h1234);
        do_read("R5 write refused without latch", 0, 6'd3, 1);

        // R5 / R8 / R9: latch set, write, busy then ready, new start bit
        do_short(2'b00, 6'b110000);
        cs_up();
        send_hdr(2'b01, 6'd3);
        send_word(16'hABCD);
        cs_dn();
        model[3] = 16'hABCD;
        cs_up();
        chk("R8 busy oe", int'(do_oe), 1);
        chk("R8 busy level", int'(do_data), 0);
        bit_io(1'b1);
        bit_io(1'b1);
        bit_io(1'b1);
        chk("R8 still busy after ignored clocks", int'(do_data), 0);
        wait_clk(PROG + 10);
        chk("R8 ready oe", int'(do_oe), 1);
        chk("R8 ready level", int'(do_data), 1);
        cs_dn();
        chk("R8 oe off with cs low", int'(do_oe), 0);
        cs_up();
        chk("R8 ready shown again", int'(do_data), 1);
        bit_io(1'b1);
        chk("R9 start bit disables output", int'(s_oe), 0);
        bit_io(1'b1);
        bit_io(1'b0);
        for (int i = 5; i >= 0; i--) bit_io(1'(6'd3 >> i));
        chk("R9 read after restart lead", int'(s_do), 0);
        begin
            logic [15:0] got;
            for (int i = 15; i >= 0; i--) begin
                bit_io(1'b0);
                got[i] = s_do;
            end
            chk("R9 R5 word written", int'(got), 16'hABCD);
        end
        cs_dn();

        // R4: fill every address, then one sequential read with wrap
        for (int a = 0; a < WORDS; a++) begin
            do_write(6'(a), pat(a));
            model[a] = pat(a);
        end
        do_read("R4 sequential sweep", 0, 6'd0, WORDS + 1);
        do_read("R4 wrap from top", 0, 6'd62, 4);

        // R6: erase one word, neighbours unchanged
        do_short(2'b11, 6'd10);
        model[10] = 16'hFFFF;
        do_read("R6 erase word", 0, 6'd9, 3);

        // R10: frames cut short by select fall
        cs_up();
        send_hdr(2'b01, 6'd20);
        for (int i = 0; i < 10; i++) bit_io(1'b0);
        cs_dn();
        wait_clk(PROG + 10);
        cs_up();
        bit_io(1'b1);
        bit_io(1'b1);
        bit_io(1'b1);
        bit_io(1'b0);
        bit_io(1'b1);
        cs_dn();
        wait_clk(PROG + 10);
        do_read("R10 partial frames discarded", 0, 6'd20, 2);

        // R11: cancel pulse before select fall
        cs_up();
        send_hdr(2'b01, 6'd22);
        send_word(16'h0000);
        guard_cancel = 1'b1;
        wait_clk(1);
        guard_cancel = 1'b0;
        cs_dn();
        wait_clk(PROG + 10);
        do_read("R11 cancelled write", 0, 6'd22, 1);

        // R12: low supply clears latch and discards a pending write
        supply_low = 1'b1;
        wait_clk(2);
        supply_low = 1'b0;
        do_write(6'd23, 16'h0F0F);
        do_read("R12 latch cleared", 0, 6'd23, 1);
        do_short(2'b00, 6'b110000);
        cs_up();
        send_hdr(2'b01, 6'd23);
        send_word(16'h0F0F);
        supply_low = 1'b1;
        wait_clk(1);
        supply_low = 1'b0;
        cs_dn();
        wait_clk(PROG + 10);
        do_read("R12 pending write dropped", 0, 6'd23, 1);

        // R7: whole-array write and erase, R5: latch clear
        do_short(2'b00, 6'b110000);
        cs_up();
        send_hdr(2'b00, 6'b010000);
        send_word(16'h5AA5);
        cs_dn();
        wait_clk(PROG + 10);
        for (int i = 0; i < WORDS; i++) model[i] = 16'h5AA5;
        do_read("R7 write-all", 0, 6'd0, WORDS);
        do_short(2'b00, 6'b100000);
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        do_read("R7 erase-all", 0, 6'd40, WORDS);
        do_short(2'b00, 6'b000000);
        do_write(6'd0, 16'h0001);
        do_read("R5 latch clear blocks write", 0, 6'd0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule